// File: doc/BRIEF.md
# Indexed Set/Clear Channel Control Registers

This block is the register front end of a multi-channel transfer controller. It keeps one bit per channel in each of four bitmaps (request enable, error, interrupt, live hardware-request status) and one priority byte per channel. Software flips a single channel's bit by writing that channel's index as one byte to a dedicated command register. No read-modify-write of the 32-bit mask is needed, so two software agents cannot race on the mask.

The channel engines report error and interrupt events as one-cycle set pulses. They take the enable mask, one-cycle start strobes, one-cycle done-clear strobes and the per-channel priorities as outputs. The priority array stores channel n's byte at byte index n XOR 3, so within each word the channel order is reversed. Software sees that order through the bus, and the engines see the priorities already unscrambled.

Command decoding is a classification of the write into a command kind (none, set enable, clear enable, clear done, set start, clear error, clear interrupt). The decoder moves from "no command" to exactly one of the other kinds for one cycle per accepted command byte and then returns to "no command".

Top module: `ccr_chan_ctrl`

## Requirements
- R1: After reset, the enable, error and interrupt bitmaps are zero, no start or done-clear strobe is active, and channel n's priority is n. The priority word at 0x100 therefore reads 0x00010203.
- R2: Writing byte value n to the set-enable command (0x010) sets bit n of the enable mask, and writing n to the clear-enable command (0x014) clears bit n. All other bits are left unchanged.
- R3: The enable mask at 0x000 can also be written as a word, and only byte lanes whose strobe bit is 1 change.
- R4: A command byte selects the channel with bits 4:0, and bits 6:5 are ignored. A command byte with bit 7 set, or written without strobe bit 0, has no effect.
- R5: Writing n to the set-start command (0x01C) drives start_o bit n high for exactly the one cycle after the write. No other bit of start_o is driven.
- R6: Writing n to the clear-done command (0x018) drives done_clr_o bit n high for exactly the one cycle after the write.
- R7: An err_set_i or int_set_i pulse sets the matching error or interrupt bit, and that bit stays set. Writing n to clear-error (0x020) or clear-interrupt (0x024) clears only bit n.
- R8: When an event sets a bit in the same cycle that a command clears it, the bit ends up set.
- R9: Reading 0x00C returns hw_req_i, sampled in the read cycle. Writes to 0x00C have no effect.
- R10: All command addresses (0x010 to 0x024) read as zero.
- R11: The priority array at 0x100 reads back exactly what was written to it. Channel n's priority is the byte at array index n XOR 3.
- R12: Read data appears on rd_data_o in the cycle after rd_en_i, and error and interrupt bitmaps read at 0x004 and 0x008.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 12 | Byte address for read and write |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| wr_strb_i | input | 4 | Byte-lane write strobes |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| hw_req_i | input | 32 | Live hardware request lines per channel |
| err_set_i | input | 32 | Error event pulses per channel |
| int_set_i | input | 32 | Interrupt event pulses per channel |
| req_en_o | output | 32 | Request-enable mask |
| err_o | output | 32 | Error bitmap |
| int_o | output | 32 | Interrupt bitmap |
| start_o | output | 32 | One-cycle start strobes |
| done_clr_o | output | 32 | One-cycle done-clear strobes |
| prio_o | output | 256 | Priority of channel n at bits 8n+7:8n |

## Verification
A decoder that picks the wrong channel or the wrong command kind is visible on req_en_o, start_o or done_clr_o in the cycle right after the command write. A bit landing elsewhere, or a neighbouring bit disturbed, shows up on the next mask read. A flag bank that loses the race between a set and a clear leaves a cleared bit on err_o or int_o one cycle later. A priority store with the wrong byte order shows up at once on prio_o for the channel, while the bus readback stays correct, so the two views are compared against each other.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int PRIO_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_EN        = 12'h000;
    localparam logic [ADDR_W-1:0] ADDR_ERR       = 12'h004;
    localparam logic [ADDR_W-1:0] ADDR_INT       = 12'h008;
    localparam logic [ADDR_W-1:0] ADDR_HWS       = 12'h00C;
    localparam logic [ADDR_W-1:0] ADDR_SET_EN    = 12'h010;
    localparam logic [ADDR_W-1:0] ADDR_CLR_EN    = 12'h014;
    localparam logic [ADDR_W-1:0] ADDR_CLR_DONE  = 12'h018;
    localparam logic [ADDR_W-1:0] ADDR_SET_START = 12'h01C;
    localparam logic [ADDR_W-1:0] ADDR_CLR_ERR   = 12'h020;
    localparam logic [ADDR_W-1:0] ADDR_CLR_INT   = 12'h024;
    localparam logic [ADDR_W-1:0] ADDR_PRIO      = 12'h100;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_SET_EN,
        CMD_CLR_EN,
        CMD_CLR_DONE,
        CMD_SET_START,
        CMD_CLR_ERR,
        CMD_CLR_INT
    } cmd_e;

endpackage

// File: rtl/ccr_cmd_decode.sv
module ccr_cmd_decode
    import ccr_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [4:0]        ch_i,
    input  logic              kill_i,
    input  logic              lane0_i,
    output cmd_e              cmd_o,
    output logic [NUM_CH-1:0] sel_o
);

    logic accept;
    cmd_e kind;

    // bit 7 of the command byte vetoes it; bits 6:5 are never looked at
    assign accept = wr_en_i && lane0_i && !kill_i && (int'(ch_i) < NUM_CH);

    always_comb begin
        unique case (addr_i)
            ADDR_SET_EN:    kind = CMD_SET_EN;
            ADDR_CLR_EN:    kind = CMD_CLR_EN;
            ADDR_CLR_DONE:  kind = CMD_CLR_DONE;
            ADDR_SET_START: kind = CMD_SET_START;
            ADDR_CLR_ERR:   kind = CMD_CLR_ERR;
            ADDR_CLR_INT:   kind = CMD_CLR_INT;
            default:        kind = CMD_NONE;
        endcase
    end

    always_comb begin
        cmd_o = accept ? kind : CMD_NONE;
        sel_o = '0;
        if (accept) sel_o[ch_i] = 1'b1;
    end

endmodule

// File: rtl/ccr_flag_bank.sv
module ccr_flag_bank #(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_i,
    input  logic [NUM_CH-1:0] clr_i,
    output logic [NUM_CH-1:0] flags_o
);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)         flags_o[n] <= 1'b0;
            else if (set_i[n])  flags_o[n] <= 1'b1;   // event beats clear
            else if (clr_i[n])  flags_o[n] <= 1'b0;
        end
    end

endmodule

// File: rtl/ccr_prio_bank.sv
module ccr_prio_bank
    import ccr_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [WIDX_W-1:0]        widx_i,
    input  logic [DATA_W-1:0]        wr_data_i,
    input  logic [3:0]               wr_strb_i,
    output logic [DATA_W-1:0]        rd_word_o,
    output logic [NUM_CH*PRIO_W-1:0] prio_o
);

    localparam int NUM_WORDS = NUM_CH / 4;
    localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    logic [NUM_CH*PRIO_W-1:0] bytes_q;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_byte
        localparam int LANE = i % 4;
        localparam int WORD = i / 4;
        always_ff @(posedge clk) begin
            if (!rst_n)
                bytes_q[i*PRIO_W +: PRIO_W] <= PRIO_W'(i ^ 3);
            else if (wr_en_i && int'(widx_i) == WORD && wr_strb_i[LANE])
                bytes_q[i*PRIO_W +: PRIO_W] <= wr_data_i[LANE*8 +: 8];
        end
        // the byte stored at index i belongs to channel i ^ 3
        assign prio_o[(i ^ 3)*PRIO_W +: PRIO_W] = bytes_q[i*PRIO_W +: PRIO_W];
    end

    assign rd_word_o = bytes_q[int'(widx_i)*DATA_W +: DATA_W];

endmodule

// File: rtl/ccr_chan_ctrl.sv
module ccr_chan_ctrl
    import ccr_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic                     wr_en_i,
    input  logic [DATA_W-1:0]        wr_data_i,
    input  logic [3:0]               wr_strb_i,
    input  logic                     rd_en_i,
    output logic [DATA_W-1:0]        rd_data_o,
    input  logic [NUM_CH-1:0]        hw_req_i,
    input  logic [NUM_CH-1:0]        err_set_i,
    input  logic [NUM_CH-1:0]        int_set_i,
    output logic [NUM_CH-1:0]        req_en_o,
    output logic [NUM_CH-1:0]        err_o,
    output logic [NUM_CH-1:0]        int_o,
    output logic [NUM_CH-1:0]        start_o,
    output logic [NUM_CH-1:0]        done_clr_o,
    output logic [NUM_CH*PRIO_W-1:0] prio_o
);

    localparam int NUM_WORDS = NUM_CH / 4;
    localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int EN_LANES  = (NUM_CH + 7) / 8;

    cmd_e              cmd;
    logic [NUM_CH-1:0] sel;
    logic [NUM_CH-1:0] err_clr, int_clr;
    logic [ADDR_W-1:0] prio_off;
    logic              prio_hit;
    logic [WIDX_W-1:0] prio_widx;
    logic [DATA_W-1:0] prio_word;
    logic [DATA_W-1:0] rd_mux;

    ccr_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .ch_i    (wr_data_i[4:0]),
        .kill_i  (wr_data_i[7]),
        .lane0_i (wr_strb_i[0]),
        .cmd_o   (cmd),
        .sel_o   (sel)
    );

    // ---- enable mask: word write per lane, or indexed set/clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_en_o <= '0;
        end else if (wr_en_i && addr_i == ADDR_EN) begin
            for (int l = 0; l < EN_LANES; l++) begin
                if (wr_strb_i[l]) begin
                    for (int b = 0; b < 8; b++) begin
                        if (l*8 + b < NUM_CH) req_en_o[l*8 + b] <= wr_data_i[l*8 + b];
                    end
                end
            end
        end else begin
            unique case (cmd)
                CMD_SET_EN: req_en_o <= req_en_o | sel;
                CMD_CLR_EN: req_en_o <= req_en_o & ~sel;
                default:    req_en_o <= req_en_o;
            endcase
        end
    end

    // ---- one-cycle strobes toward the channel engines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o    <= '0;
            done_clr_o <= '0;
        end else begin
            start_o    <= (cmd == CMD_SET_START) ? sel : '0;
            done_clr_o <= (cmd == CMD_CLR_DONE)  ? sel : '0;
        end
    end

    assign err_clr = (cmd == CMD_CLR_ERR) ? sel : '0;
    assign int_clr = (cmd == CMD_CLR_INT) ? sel : '0;

    ccr_flag_bank #(.NUM_CH(NUM_CH)) u_err (
        .clk(clk), .rst_n(rst_n), .set_i(err_set_i), .clr_i(err_clr), .flags_o(err_o)
    );

    ccr_flag_bank #(.NUM_CH(NUM_CH)) u_int (
        .clk(clk), .rst_n(rst_n), .set_i(int_set_i), .clr_i(int_clr), .flags_o(int_o)
    );

    // ---- priority array
    assign prio_off  = addr_i - ADDR_PRIO;
    assign prio_hit  = (addr_i >= ADDR_PRIO) && (prio_off < ADDR_W'(NUM_CH));
    assign prio_widx = prio_off[2 +: WIDX_W];

    ccr_prio_bank #(.NUM_CH(NUM_CH)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i && prio_hit),
        .widx_i    (prio_widx),
        .wr_data_i (wr_data_i),
        .wr_strb_i (wr_strb_i),
        .rd_word_o (prio_word),
        .prio_o    (prio_o)
    );

    // ---- read path, one cycle latency
    always_comb begin
        rd_mux = '0;
        if (prio_hit) begin
            rd_mux = prio_word;
        end else begin
            unique case (addr_i)
                ADDR_EN:  rd_mux = DATA_W'(req_en_o);
                ADDR_ERR: rd_mux = DATA_W'(err_o);
                ADDR_INT: rd_mux = DATA_W'(int_o);
                ADDR_HWS: rd_mux = DATA_W'(hw_req_i);
                default:  rd_mux = '0;   // command bytes read as zero
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data_o <= '0;
        else if (rd_en_i) rd_data_o <= rd_mux;
    end

endmodule

// File: rtl/ccr_chan_ctrl_chk.sv
module ccr_chan_ctrl_chk
    import ccr_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [ADDR_W-1:0]        addr_i,
    input logic                     wr_en_i,
    input logic [DATA_W-1:0]        wr_data_i,
    input logic                     rd_en_i,
    input logic [DATA_W-1:0]        rd_data_o,
    input logic [NUM_CH-1:0]        err_set_i,
    input logic [NUM_CH-1:0]        int_set_i,
    input logic [NUM_CH-1:0]        req_en_o,
    input logic [NUM_CH-1:0]        err_o,
    input logic [NUM_CH-1:0]        int_o,
    input logic [NUM_CH-1:0]        start_o,
    input logic [NUM_CH-1:0]        done_clr_o
);

    AST_EN_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en_o != $past(req_en_o)) |-> $past(wr_en_i)); // R2

    AST_EN_CMD_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en_i && (addr_i == ADDR_SET_EN || addr_i == ADDR_CLR_EN))
        |-> ($countones(req_en_o ^ $past(req_en_o)) <= 1)); // R2

    AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_o)); // R5

    AST_START_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (|start_o) |-> $past(wr_en_i && addr_i == ADDR_SET_START && !wr_data_i[7])); // R5

    AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_clr_o)); // R6

    AST_ERR_FALL_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        ((~err_o & $past(err_o)) != '0) |-> $past(wr_en_i && addr_i == ADDR_CLR_ERR)); // R7

    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_o & $past(err_set_i)) == $past(err_set_i))); // R8

    AST_INT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((int_o & $past(int_set_i)) == $past(int_set_i))); // R8

    AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en_i && addr_i >= ADDR_SET_EN && addr_i <= ADDR_CLR_INT)
        |-> (rd_data_o == '0)); // R10

endmodule

bind ccr_chan_ctrl ccr_chan_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/test_ccr_chan_ctrl.sv
module test_ccr_chan_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [11:0]       addr = '0;
    logic              wr_en = 1'b0;
    logic [31:0]       wr_data = '0;
    logic [3:0]        wr_strb = '0;
    logic              rd_en = 1'b0;
    logic [31:0]       rd_data;
    logic [NCH-1:0]    hw_req = '0;
    logic [NCH-1:0]    err_set = '0;
    logic [NCH-1:0]    int_set = '0;
    logic [NCH-1:0]    req_en, err_q, int_q, start, done_clr;
    logic [NCH*8-1:0]  prio;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccr_chan_ctrl #(.NUM_CH(NCH)) i_ccr_chan_ctrl (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .wr_strb_i(wr_strb), .rd_en_i(rd_en), .rd_data_o(rd_data), .hw_req_i(hw_req),
        .err_set_i(err_set), .int_set_i(int_set), .req_en_o(req_en), .err_o(err_q),
        .int_o(int_q), .start_o(start), .done_clr_o(done_clr), .prio_o(prio)
    );

    typedef struct packed {
        logic        rd;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 12'h010, 32'd5,          32'h0,          8'd2},  // R2 set ch5
        '{1'b1, 12'h000, 32'h0,          32'h0000_0020,  8'd2},
        '{1'b0, 12'h010, 32'd31,         32'h0,          8'd2},  // R2 set ch31
        '{1'b1, 12'h000, 32'h0,          32'h8000_0020,  8'd2},
        '{1'b0, 12'h014, 32'd5,          32'h0,          8'd2},  // R2 clear ch5
        '{1'b1, 12'h000, 32'h0,          32'h8000_0000,  8'd2},
        '{1'b0, 12'h010, 32'h85,         32'h0,          8'd4},  // R4 bit7 vetoes
        '{1'b1, 12'h000, 32'h0,          32'h8000_0000,  8'd4},
        '{1'b0, 12'h010, 32'h62,         32'h0,          8'd4},  // R4 bits 6:5 ignored -> ch2
        '{1'b1, 12'h000, 32'h0,          32'h8000_0004,  8'd4},
        '{1'b1, 12'h010, 32'h0,          32'h0,          8'd10}, // R10
        '{1'b1, 12'h01C, 32'h0,          32'h0,          8'd10}, // R10
        '{1'b0, 12'h100, 32'h1122_3344,  32'h0,          8'd11}, // R11
        '{1'b1, 12'h100, 32'h0,          32'h1122_3344,  8'd11},
        '{1'b0, 12'h00C, 32'hFFFF_FFFF,  32'h0,          8'd9},  // R9 write ignored
        '{1'b1, 12'h00C, 32'h0,          32'h0000_A5A5,  8'd9}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
        addr = a; wr_data = d; wr_strb = s; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_strb = '0;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        logic        prio_ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 req_en", req_en, 32'h0);
        chk("R1 err", err_q, 32'h0);
        chk("R1 int", int_q, 32'h0);
        chk("R1 strobes", start | done_clr, 32'h0);
        prio_ok = 1'b1;
        for (int n = 0; n < NCH; n++) if (prio[n*8 +: 8] !== 8'(n)) prio_ok = 1'b0;
        chk("R1 prio per channel", {31'd0, prio_ok}, 32'd1);
        do_read(12'h100, r);
        chk("R1 prio word0", r, 32'h0001_0203);

        // table walk
        hw_req = 32'h0000_A5A5;
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].rd) begin
                do_read(VEC[i].addr, r);
                chk($sformatf("R%0d vec%0d", VEC[i].req, i), r, VEC[i].exp);
            end else begin
                do_write(VEC[i].addr, VEC[i].data, 4'hF);
            end
        end

        // R11 unscrambled view after writing 0x11223344 to word 0
        chk("R11 ch0 prio", {24'd0, prio[0 +: 8]}, 32'h11);
        chk("R11 ch3 prio", {24'd0, prio[24 +: 8]}, 32'h44);
        chk("R11 ch4 untouched", {24'd0, prio[32 +: 8]}, 32'h04);

        // R3 byte-lane word write of enable mask
        do_write(12'h000, 32'h1234_5678, 4'b0101);
        chk("R3 lanes", req_en, 32'h8034_0078);

        // R4 command without lane 0 strobe ignored
        do_write(12'h010, 32'd9, 4'b1110);
        chk("R4 no lane0", req_en, 32'h8034_0078);

        // R5 start strobe
        do_write(12'h01C, 32'd9, 4'h1);
        chk("R5 start high", start, 32'h0000_0200);
        @(negedge clk);
        chk("R5 start low", start, 32'h0);

        // R6 done-clear strobe
        do_write(12'h018, 32'd17, 4'h1);
        chk("R6 done_clr high", done_clr, 32'h0002_0000);
        @(negedge clk);
        chk("R6 done_clr low", done_clr, 32'h0);

        // R7 sticky flags and indexed clear
        err_set = 32'h18; int_set = 32'h3;
        @(negedge clk);
        err_set = '0; int_set = '0;
        @(negedge clk);
        chk("R7 err sticky", err_q, 32'h18);
        do_write(12'h020, 32'd3, 4'h1);
        chk("R7 err clear ch3", err_q, 32'h10);
        do_write(12'h024, 32'd0, 4'h1);
        chk("R7 int clear ch0", int_q, 32'h2);
        do_read(12'h004, r);
        chk("R12 err read", r, 32'h10);
        do_read(12'h008, r);
        chk("R12 int read", r, 32'h2);

        // R8 set beats clear in the same cycle
        err_set = 32'h10;
        do_write(12'h020, 32'd4, 4'h1);
        err_set = '0;
        chk("R8 err set wins", err_q, 32'h10);
        int_set = 32'h2;
        do_write(12'h024, 32'd1, 4'h1);
        int_set = '0;
        chk("R8 int set wins", int_q, 32'h2);

        // R9 live status
        hw_req = 32'h8000_0001;
        do_read(12'h00C, r);
        chk("R9 hw status", r, 32'h8000_0001);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule